// File: doc/BRIEF.md
# Misaligned Load/Store Splitter with Byte-Lane Steering

This block sits between a load/store unit and a 64-bit internal bus. It accepts one request at a time. A request carries a byte address, an access size (byte, halfword, word or doubleword), a read/write flag and, for stores, right-justified store data. The block turns the request into one bus transfer, or into two transfers when the requested bytes run past the end of the current 8-byte doubleword. Each transfer carries a byte-lane strobe, a size code, an unaligned flag and store data that has already been moved onto the correct lanes.

The size code on the bus does not simply repeat the request size. It names the smallest naturally aligned container that holds the transfer's bytes. The one exception is the first half of a split, which keeps the request's own size code. Load data returned by the bus is shifted back to byte 0 and merged across the two halves of a split. It is handed to the requester together with the acknowledge. The second transfer is issued only after the first has been accepted. The requester is acknowledged once the last transfer has been accepted.

Top module: `misalign_splitter`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `xfer_valid` and `req_ready` are 0. A reset in the middle of a split drops the pending second transfer.
- R2: `xfer_strb` bit i is 1 exactly when the transfer moves the byte at offset i of its doubleword. Bit 0 is the lowest address, because the bus is little-endian.
- R3: The size code encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. For a single transfer, and for the second transfer of a split, it is the smallest naturally aligned 1/2/4/8-byte container that holds every strobed byte.
- R4: The first transfer of a split carries the size code of the request itself.
- R5: `xfer_unaligned` is 1 exactly when the number of strobed bytes differs from the byte count named by the size code.
- R6: A request whose offset plus byte count exceeds 8 becomes two transfers. The first goes to the request address. The second goes to offset 0 of the following doubleword and covers the remaining bytes. Any other request becomes exactly one transfer.
- R7: The second transfer of a split appears only after the first is accepted (`xfer_valid` and `xfer_ready` both 1). While `xfer_ready` is 0, the presented transfer is held unchanged.
- R8: `req_ready` is a one-cycle pulse in the cycle after the last transfer is accepted, and `xfer_valid` is 0 during that pulse.
- R9: On a write, request byte k (`req_wdata` bits 8k+7:8k) appears on the lane of address (request address + k) in whichever transfer covers that address.
- R10: On a read, `req_rdata` byte k during the `req_ready` pulse is the bus byte returned for address (request address + k), for k below the access byte count. The bytes above the byte count are 0.
- R11: A naturally aligned request is a single transfer with the request's size code and `xfer_unaligned` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_ready | output | 1 | One-cycle acknowledge after the last transfer |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | Request size code (0..3 = 1..8 bytes) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 64 | Store data, byte 0 at the least significant byte |
| req_rdata | output | 64 | Load data, valid with `req_ready` |
| xfer_valid | output | 1 | Bus transfer presented |
| xfer_ready | input | 1 | Bus accepts the transfer and returns read data this cycle |
| xfer_addr | output | ADDR_W | Byte address of the transfer |
| xfer_size | output | 2 | Container size code |
| xfer_strb | output | 8 | Byte-lane enables, bit i = offset i |
| xfer_unaligned | output | 1 | Strobed byte count differs from container size |
| xfer_write | output | 1 | Transfer direction |
| xfer_wdata | output | 64 | Lane-steered store data |
| xfer_rdata | input | 64 | Bus read data, lane i = offset i |

## Verification
A phase register that is wrong shows at the ports within one cycle. It appears as a missing or extra transfer, as a second transfer that does not start at offset 0, or as an acknowledge that overlaps `xfer_valid` or lasts two cycles. A latched offset or size that is wrong shows in the first presented transfer as a wrong strobe, size code or lane placement. A fault in the load-data accumulator stays hidden until the acknowledge, where the merged bytes or the zeroed upper bytes differ from the bus bytes at the request addresses. Every offset of every size is exercised for both directions, some with a held-off bus, and a reset is applied in the middle of a split.

// File: rtl/lsu_split_pkg.sv
package lsu_split_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FIRST,
        PH_SECOND,
        PH_ACK
    } phase_e;

endpackage

// File: rtl/lane_plan.sv
module lane_plan #(
    parameter int LANES = 8,
    localparam int OFF_W  = $clog2(LANES),
    localparam int SZ_W   = $clog2(OFF_W + 1),
    localparam int SPAN_W = OFF_W + 2
) (
    input  logic [OFF_W-1:0] off_i,
    input  logic [SZ_W-1:0]  size_i,
    input  logic             second_i,
    output logic [LANES-1:0] strb_o,
    output logic [SZ_W-1:0]  size_o,
    output logic             unaligned_o,
    output logic             split_o
);

    logic [SPAN_W-1:0] nbytes;
    logic [SPAN_W-1:0] last_b;
    logic [SPAN_W-1:0] lo_b;
    logic [SPAN_W-1:0] hi_b;
    logic [SPAN_W-1:0] cnt_b;
    logic [SZ_W-1:0]   fit;

    // byte span of the part being presented
    always_comb begin
        nbytes  = SPAN_W'(1) << size_i;
        last_b  = SPAN_W'(off_i) + nbytes - SPAN_W'(1);
        split_o = last_b >= SPAN_W'(LANES);
        if (second_i) begin
            lo_b = '0;
            hi_b = last_b - SPAN_W'(LANES);
        end else begin
            lo_b = SPAN_W'(off_i);
            hi_b = split_o ? SPAN_W'(LANES - 1) : last_b;
        end
        cnt_b = hi_b - lo_b + SPAN_W'(1);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign strb_o[i] = (SPAN_W'(i) >= lo_b) && (SPAN_W'(i) <= hi_b);
    end

    // smallest aligned container holding lo_b..hi_b
    always_comb begin
        fit = SZ_W'(OFF_W);
        for (int k = OFF_W - 1; k >= 0; k--) begin
            if ((lo_b >> k) == (hi_b >> k)) begin
                fit = SZ_W'(k);
            end
        end
        size_o      = (split_o && !second_i) ? size_i : fit;
        unaligned_o = cnt_b != (SPAN_W'(1) << size_o);
    end

endmodule

// File: rtl/data_steer.sv
module data_steer #(
    parameter int LANES = 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int SZ_W  = $clog2(OFF_W + 1),
    localparam int DW    = 8 * LANES,
    localparam int SH_W  = $clog2(DW) + 1
) (
    input  logic [OFF_W-1:0] off_i,
    input  logic [SZ_W-1:0]  size_i,
    input  logic             second_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [DW-1:0]    bus_rdata_i,
    input  logic [DW-1:0]    acc_rdata_i,
    output logic [DW-1:0]    bus_wdata_o,
    output logic [DW-1:0]    merged_o
);

    logic [SH_W-1:0] lo_sh;
    logic [SH_W-1:0] hi_sh;
    logic [DW-1:0]   keep;

    assign lo_sh = SH_W'(off_i) << 3;
    assign hi_sh = SH_W'(DW) - lo_sh;

    for (genvar b = 0; b < LANES; b++) begin : g_keep
        assign keep[8*b +: 8] = {8{32'(b) < (32'(1) << size_i)}};
    end

    // store data onto address lanes; load data back to byte 0
    assign bus_wdata_o = second_i ? (wdata_i >> hi_sh) : (wdata_i << lo_sh);
    assign merged_o    = keep & (second_i ? (acc_rdata_i | (bus_rdata_i << hi_sh))
                                          : (bus_rdata_i >> lo_sh));

endmodule

// File: rtl/misalign_splitter.sv
module misalign_splitter
    import lsu_split_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANES  = 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int SZ_W  = $clog2(OFF_W + 1),
    localparam int DW    = 8 * LANES,
    localparam int DWA_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SZ_W-1:0]   req_size,
    input  logic              req_write,
    input  logic [DW-1:0]     req_wdata,
    output logic [DW-1:0]     req_rdata,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [SZ_W-1:0]   xfer_size,
    output logic [LANES-1:0]  xfer_strb,
    output logic              xfer_unaligned,
    output logic              xfer_write,
    output logic [DW-1:0]     xfer_wdata,
    input  logic [DW-1:0]     xfer_rdata
);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [SZ_W-1:0]   size;
        logic              write;
        logic [DW-1:0]     wdata;
        logic [DW-1:0]     rdata;
    } st_t;

    st_t st_d, st_q;

    logic          second;
    logic          split;
    logic [DW-1:0] merged;
    logic [DWA_W-1:0] next_dw;

    assign second  = st_q.phase == PH_SECOND;
    assign next_dw = st_q.addr[ADDR_W-1:OFF_W] + DWA_W'(1);

    lane_plan #(.LANES(LANES)) u_plan (
        .off_i      (st_q.addr[OFF_W-1:0]),
        .size_i     (st_q.size),
        .second_i   (second),
        .strb_o     (xfer_strb),
        .size_o     (xfer_size),
        .unaligned_o(xfer_unaligned),
        .split_o    (split)
    );

    data_steer #(.LANES(LANES)) u_steer (
        .off_i      (st_q.addr[OFF_W-1:0]),
        .size_i     (st_q.size),
        .second_i   (second),
        .wdata_i    (st_q.wdata),
        .bus_rdata_i(xfer_rdata),
        .acc_rdata_i(st_q.rdata),
        .bus_wdata_o(xfer_wdata),
        .merged_o   (merged)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase = PH_FIRST;
                    st_d.addr  = req_addr;
                    st_d.size  = req_size;
                    st_d.write = req_write;
                    st_d.wdata = req_wdata;
                    st_d.rdata = '0;
                end
            end
            PH_FIRST: begin
                if (xfer_ready) begin
                    st_d.rdata = merged;
                    st_d.phase = split ? PH_SECOND : PH_ACK;
                end
            end
            PH_SECOND: begin
                if (xfer_ready) begin
                    st_d.rdata = merged;
                    st_d.phase = PH_ACK;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign xfer_valid = (st_q.phase == PH_FIRST) || second;
    assign xfer_addr  = second ? {next_dw, {OFF_W{1'b0}}} : st_q.addr;
    assign xfer_write = st_q.write;
    assign req_ready  = st_q.phase == PH_ACK;
    assign req_rdata  = st_q.rdata;

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_strb)); // R7

    AST_SECOND_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && xfer_ready && st_q.phase == PH_FIRST && split
        |=> xfer_valid && (xfer_addr[OFF_W-1:0] == '0)); // R6

    AST_STRB_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (xfer_strb != '0) && ($countones(xfer_strb) <= (1 << xfer_size))); // R3

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready); // R8

    AST_ACK_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !xfer_valid); // R8

endmodule

// File: tb/test_misalign_splitter.sv
`timescale 1ns/1ps
module test_misalign_splitter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [63:0] req_rdata;
    logic        xfer_valid;
    logic        xfer_ready = 1'b0;
    logic [31:0] xfer_addr;
    logic [1:0]  xfer_size;
    logic [7:0]  xfer_strb;
    logic        xfer_unaligned;
    logic        xfer_write;
    logic [63:0] xfer_wdata;
    logic [63:0] xfer_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    misalign_splitter i_misalign_splitter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .req_rdata(req_rdata),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
        .xfer_size(xfer_size), .xfer_strb(xfer_strb), .xfer_unaligned(xfer_unaligned),
        .xfer_write(xfer_write), .xfer_wdata(xfer_wdata), .xfer_rdata(xfer_rdata)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    // bus responder: lane i returns the byte of offset i
    always_comb begin
        for (int i = 0; i < 8; i++) begin
            xfer_rdata[8*i +: 8] = mem_byte({xfer_addr[31:3], 3'b000} + 32'(i));
        end
    end

    // {size, off, strb0, sz0, un0, two, strb1, sz1, un1}; strobe bit i = offset i
    localparam logic [27:0] VEC [32] = '{
        {2'd0,3'd0,8'b0000_0001,2'd0,1'b0,1'b0,8'h00,2'd0,1'b0},
        {2'd0,3'd1,8'b0000_0010,2'd0,1'b0,1'b0,8'h00,2'd0,1'b0},
        {2'd0,3'd2,8'b0000_0100,2'd0,1'b0,1'b0,8'h00,2'd0,1'b0},
        {2'd0,3'd3,8'b0000_1000,2'd0,1'b0,1'b0,8'h00,2'd0,1'b0},
        {2'd0,3'd4,8'b0001_0000,2'd0,1'b0,1'b0,8'h00,2'd0,1'b0},
        {2'd0,3'd5,8'b0010_0000,2'd0,1'b0,1'b0,8'h00,2'd0,1'b0},
        {2'd0,3'd6,8'b0100_0000,2'd0,1'b0,1'b0,8'h00,2'd0,1'b0},
        {2'd0,3'd7,8'b1000_0000,2'd0,1'b0,1'b0,8'h00,2'd0,1'b0},
        {2'd1,3'd0,8'b0000_0011,2'd1,1'b0,1'b0,8'h00,2'd0,1'b0},
        {2'd1,3'd1,8'b0000_0110,2'd2,1'b1,1'b0,8'h00,2'd0,1'b0},
        {2'd1,3'd2,8'b0000_1100,2'd1,1'b0,1'b0,8'h00,2'd0,1'b0},
        {2'd1,3'd3,8'b0001_1000,2'd3,1'b1,1'b0,8'h00,2'd0,1'b0},
        {2'd1,3'd4,8'b0011_0000,2'd1,1'b0,1'b0,8'h00,2'd0,1'b0},
        {2'd1,3'd5,8'b0110_0000,2'd2,1'b1,1'b0,8'h00,2'd0,1'b0},
        {2'd1,3'd6,8'b1100_0000,2'd1,1'b0,1'b0,8'h00,2'd0,1'b0},
        {2'd1,3'd7,8'b1000_0000,2'd1,1'b1,1'b1,8'b0000_0001,2'd0,1'b0},
        {2'd2,3'd0,8'b0000_1111,2'd2,1'b0,1'b0,8'h00,2'd0,1'b0},
        {2'd2,3'd1,8'b0001_1110,2'd3,1'b1,1'b0,8'h00,2'd0,1'b0},
        {2'd2,3'd2,8'b0011_1100,2'd3,1'b1,1'b0,8'h00,2'd0,1'b0},
        {2'd2,3'd3,8'b0111_1000,2'd3,1'b1,1'b0,8'h00,2'd0,1'b0},
        {2'd2,3'd4,8'b1111_0000,2'd2,1'b0,1'b0,8'h00,2'd0,1'b0},
        {2'd2,3'd5,8'b1110_0000,2'd2,1'b1,1'b1,8'b0000_0001,2'd0,1'b0},
        {2'd2,3'd6,8'b1100_0000,2'd2,1'b1,1'b1,8'b0000_0011,2'd1,1'b0},
        {2'd2,3'd7,8'b1000_0000,2'd2,1'b1,1'b1,8'b0000_0111,2'd2,1'b1},
        {2'd3,3'd0,8'b1111_1111,2'd3,1'b0,1'b0,8'h00,2'd0,1'b0},
        {2'd3,3'd1,8'b1111_1110,2'd3,1'b1,1'b1,8'b0000_0001,2'd0,1'b0},
        {2'd3,3'd2,8'b1111_1100,2'd3,1'b1,1'b1,8'b0000_0011,2'd1,1'b0},
        {2'd3,3'd3,8'b1111_1000,2'd3,1'b1,1'b1,8'b0000_0111,2'd2,1'b1},
        {2'd3,3'd4,8'b1111_0000,2'd3,1'b1,1'b1,8'b0000_1111,2'd2,1'b0},
        {2'd3,3'd5,8'b1110_0000,2'd3,1'b1,1'b1,8'b0001_1111,2'd3,1'b1},
        {2'd3,3'd6,8'b1100_0000,2'd3,1'b1,1'b1,8'b0011_1111,2'd3,1'b1},
        {2'd3,3'd7,8'b1000_0000,2'd3,1'b1,1'b1,8'b0111_1111,2'd3,1'b1}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input int idx, input bit wr, input bit stall);
        logic [27:0] v;
        logic [1:0]  sz;
        logic [2:0]  off;
        logic [31:0] a;
        logic [63:0] wd;
        logic [63:0] exp_rd;
        logic [63:0] exp_w;
        logic [63:0] lmask;
        logic [7:0]  e_strb;
        logic [1:0]  e_sz;
        logic        e_un;
        int          nx;
        int          nbytes;
        bit          stalled;
        bit          done;
        v   = VEC[idx];
        sz  = v[27:26];
        off = v[25:23];
        nbytes = 1 << sz;
        a   = 32'h1000 + 32'(idx) * 32'h40 + 32'(off);
        wd  = 64'hF1E2_D3C4_B5A6_9788 ^ {8{8'(idx)}};
        exp_rd = '0;
        for (int k = 0; k < 8; k++) begin
            if (k < nbytes) exp_rd[8*k +: 8] = mem_byte(a + 32'(k));
        end
        nx = 0; stalled = 0; done = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
        for (int c = 0; c < 12 && !done; c++) begin
            @(negedge clk);
            if (req_ready) begin
                done = 1;
                chk(!xfer_valid, "R8 xfer_valid during ack", 64'(xfer_valid), 64'd0);
                chk(nx == (v[11] ? 2 : 1), "R6 transfer count", 64'(nx), v[11] ? 64'd2 : 64'd1);
                if (!wr) chk(req_rdata == exp_rd, "R10 merged read data", req_rdata, exp_rd);
                req_valid = 1'b0;
                xfer_ready = 1'b0;
            end else if (xfer_valid) begin
                if (nx == 0) begin
                    e_strb = v[22:15]; e_sz = v[14:13]; e_un = v[12];
                end else begin
                    e_strb = v[10:3]; e_sz = v[2:1]; e_un = v[0];
                end
                chk(nx < (v[11] ? 2 : 1), "R6 extra transfer", 64'(nx), 64'(v[11]));
                chk(xfer_strb == e_strb, "R2 strobe", 64'(xfer_strb), 64'(e_strb));
                chk(xfer_size == e_sz, (nx == 0 && v[11]) ? "R4 split first size" :
                    (v[11] || off == 3'(0) || (32'(off) % nbytes) == 0) ? "R3 size code" : "R3 size code",
                    64'(xfer_size), 64'(e_sz));
                chk(xfer_unaligned == e_un, "R5 unaligned flag", 64'(xfer_unaligned), 64'(e_un));
                if ((32'(off) % nbytes) == 0)
                    chk(xfer_size == sz && !xfer_unaligned, "R11 aligned passthrough",
                        64'({xfer_size, xfer_unaligned}), 64'({sz, 1'b0}));
                if (nx == 0)
                    chk(xfer_addr == a, "R6 first address", 64'(xfer_addr), 64'(a));
                else
                    chk(xfer_addr == {a[31:3], 3'b000} + 32'd8, "R6 second address",
                        64'(xfer_addr), 64'({a[31:3], 3'b000} + 32'd8));
                chk(xfer_write == wr, "R9 direction", 64'(xfer_write), 64'(wr));
                if (wr) begin
                    exp_w = '0; lmask = '0;
                    for (int i = 0; i < 8; i++) begin
                        if (e_strb[i]) begin
                            lmask[8*i +: 8] = 8'hFF;
                            exp_w[8*i +: 8] = wd[8*((nx == 0) ? (i - int'(off)) : (i + 8 - int'(off))) +: 8];
                        end
                    end
                    chk((xfer_wdata & lmask) == exp_w, "R9 store lanes", xfer_wdata & lmask, exp_w);
                end
                if (stall && !stalled) begin
                    stalled = 1;
                    xfer_ready = 1'b0;
                end else begin
                    xfer_ready = 1'b1;
                    nx++;
                end
            end else begin
                chk(c == 0 && nx == 0, "R7 gap between transfers", 64'(nx), 64'(c));
            end
        end
        if (!done) chk(1'b0, "R8 no acknowledge", 64'd0, 64'd1);
        @(negedge clk);
        chk(!req_ready && !xfer_valid, "R8 single ack pulse", 64'({req_ready, xfer_valid}), 64'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog expired actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1;
        chk(!xfer_valid && !req_ready, "R1 in reset", 64'({xfer_valid, req_ready}), 64'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!xfer_valid && !req_ready, "R1 after release", 64'({xfer_valid, req_ready}), 64'd0);

        for (int idx = 0; idx < 32; idx++) begin
            run_vec(idx, 1'b1, idx[0]);
            run_vec(idx, 1'b0, !idx[0]);
        end

        // reset while the second half of a split is pending (doubleword at offset 7)
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h2007; req_size = 2'd3; req_write = 1'b0;
        xfer_ready = 1'b1;
        @(negedge clk);
        chk(xfer_valid && xfer_addr == 32'h2007, "R6 first before reset", 64'(xfer_addr), 64'h2007);
        @(negedge clk);
        chk(xfer_valid && xfer_addr == 32'h2008, "R6 second before reset", 64'(xfer_addr), 64'h2008);
        xfer_ready = 1'b0; req_valid = 1'b0; rst_n = 1'b0;
        #1;
        chk(!xfer_valid && !req_ready, "R1 reset mid split", 64'({xfer_valid, req_ready}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!xfer_valid && !req_ready, "R1 idle after mid split reset", 64'({xfer_valid, req_ready}), 64'd0);

        run_vec(23, 1'b0, 1'b1);
        run_vec(29, 1'b1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule